// File: doc/BRIEF.md
# Two-Level Composed Binary Decoder

This block turns an 8-bit code and an active-high enable into a 256-bit one-hot vector. The single line set is the one whose index equals the code, and only while the enable is high. The wide decoder is not written as one flat comparator bank. It is assembled from identical 4-bit enabled decoders arranged in two levels.

A compile-time parameter picks one of two compositions. In the coincident (AND-pair) composition, the upper nibble and the lower nibble are each decoded once. Every output is then the AND of one upper line and one lower line. The external enable reaches only the upper-nibble decoder, and the lower-nibble decoder is always enabled. In the tree composition, a first-level decoder turns the upper nibble and the external enable into sixteen enables. Each of these enables one second-level decoder, and that decoder decodes the lower nibble onto its own group of sixteen outputs.

The port list is the same for both choices and so is the function, so an integrator can switch between them to trade gate count against depth without touching the surrounding logic.

Top module: `wide_decoder`

## Requirements
- R1: While `en_i` is 1, `onehot_o` has exactly one bit set, and that bit is at index `code_i` read as an unsigned number.
- R2: While `en_i` is 0, every bit of `onehot_o` is 0, whatever the value of `code_i`.
- R3: The code is split into an upper nibble H (bits 7..4) and a lower nibble L (bits 3..0), and the selected output index is 16*H + L. For example, code 0x24 sets `onehot_o[36]` and code 0x42 sets `onehot_o[66]`.
- R4: For every code and enable value, the two compositions (`STYLE` = `COMPOSE_COINCIDENT` or `COMPOSE_TREE`) give identical outputs bit for bit.
- R5: Each 4-bit sub-decoder drives all of its sixteen outputs to 0 whenever its own enable is 0. In the tree composition, this means that only the group 16*H .. 16*H+15 can hold the set bit.
- R6: The extreme and sample codes decode correctly with the enable high: 0x00 sets bit 0 only, 0xFF sets bit 255 only, and 0x06 sets bit 6 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 8 (2*SUB_W) | Code to decode; upper nibble selects the group, lower nibble the line in it |
| en_i | input | 1 | Active-high enable; when low all outputs are 0 |
| onehot_o | output | 256 (2**(2*SUB_W)) | One-hot decoded output |

## Verification
The embedded assertions check, on every evaluation, that a disabled block drives no line, that an enabled block drives exactly one line, and that this line is the one the code addresses. Inside each composition they also check that every sub-decoder is silent while its enable is low and that no line outside the addressed group is set. Agreement between the two compositions cannot be seen from inside either instance. Only the bench shows it, because it drives both structures with the same stimulus and compares each of them with its own reference over every code and both enable values.

// File: rtl/dec_pkg.sv
// Package: shared types for the composed decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package dec_pkg;

    // Structure choice for the two-level decoder
    typedef enum logic {
        COMPOSE_COINCIDENT = 1'b0,
        COMPOSE_TREE       = 1'b1
    } compose_e;

endpackage

// File: rtl/dec_unit.sv
// Module: dec_unit
// An enabled W-input binary decoder with 2**W one-hot outputs.
// Assumes: purely combinational; all outputs are 0 when en_i is low.
module dec_unit #(
    parameter int W = 4
) (
    input  logic [W-1:0]    sel_i,
    input  logic            en_i,
    output logic [(1<<W)-1:0] line_o
);
    localparam int N = 1 << W;

    // One comparator per output line, gated by the enable
    for (genvar i = 0; i < N; i++) begin : g_line
        assign line_o[i] = en_i && (sel_i == W'(i));
    end

    // Guard: a disabled unit drives nothing, an enabled one drives one line
    always_comb begin
        AST_UNIT_SILENT: assert (en_i || (line_o == '0))
            else $error("sub-decoder active while disabled"); // R5
        AST_UNIT_SINGLE: assert (!en_i || ($countones(line_o) == 1))
            else $error("sub-decoder not one-hot while enabled"); // R5
    end

endmodule

// File: rtl/dec_coincident.sv
// Module: dec_coincident
// Two-level decoder built as AND pairs: upper and lower halves are decoded
// separately and output 16*s+t is the AND of upper line s and lower line t.
// Assumes: only the upper decoder sees the external enable.
module dec_coincident #(
    parameter int SUB_W = 4
) (
    input  logic [2*SUB_W-1:0]        code_i,
    input  logic                      en_i,
    output logic [(1<<(2*SUB_W))-1:0] line_o
);
    localparam int SUB_N = 1 << SUB_W;

    logic [SUB_N-1:0] hi_line;
    logic [SUB_N-1:0] lo_line;

    // Upper half carries the external enable
    dec_unit #(.W(SUB_W)) u_hi (
        .sel_i  (code_i[2*SUB_W-1:SUB_W]),
        .en_i   (en_i),
        .line_o (hi_line)
    );

    // Lower half is permanently enabled
    dec_unit #(.W(SUB_W)) u_lo (
        .sel_i  (code_i[SUB_W-1:0]),
        .en_i   (1'b1),
        .line_o (lo_line)
    );

    // AND matrix: one gate per output
    for (genvar s = 0; s < SUB_N; s++) begin : g_row
        for (genvar t = 0; t < SUB_N; t++) begin : g_col
            assign line_o[s*SUB_N + t] = hi_line[s] & lo_line[t];
        end
    end

    // Guard: the lower decoder always presents a line; the matrix adds no extra bits
    always_comb begin
        AST_LOW_ALWAYS_ON: assert ($countones(lo_line) == 1)
            else $error("lower decoder idle in coincident mode"); // R3
        AST_MATRIX_ROW: assert ((line_o == '0) == (hi_line == '0))
            else $error("AND matrix disagrees with upper decoder"); // R5
    end

endmodule

// File: rtl/dec_tree.sv
// Module: dec_tree
// Two-level decoder built as an enable tree: a first-level unit decodes the
// upper half and enables one of 2**SUB_W second-level units on the lower half.
// Assumes: second-level unit t owns outputs 16*t .. 16*t+15.
module dec_tree #(
    parameter int SUB_W = 4
) (
    input  logic [2*SUB_W-1:0]        code_i,
    input  logic                      en_i,
    output logic [(1<<(2*SUB_W))-1:0] line_o
);
    localparam int SUB_N = 1 << SUB_W;

    logic [SUB_N-1:0] grp_en;

    // First level: upper half selects the group
    dec_unit #(.W(SUB_W)) u_root (
        .sel_i  (code_i[2*SUB_W-1:SUB_W]),
        .en_i   (en_i),
        .line_o (grp_en)
    );

    // Second level: one unit per group on the lower half
    for (genvar t = 0; t < SUB_N; t++) begin : g_leaf
        dec_unit #(.W(SUB_W)) u_leaf (
            .sel_i  (code_i[SUB_W-1:0]),
            .en_i   (grp_en[t]),
            .line_o (line_o[t*SUB_N +: SUB_N])
        );
    end

    // Guard: set bit, if any, lies in the group named by the upper half
    always_comb begin
        AST_GROUP_LOCAL: assert (!en_i ||
            (line_o[code_i[2*SUB_W-1:SUB_W]*SUB_N +: SUB_N] != '0))
            else $error("set bit outside addressed group"); // R5
    end

endmodule

// File: rtl/wide_decoder.sv
// Module: wide_decoder
// 2*SUB_W-input binary decoder with enable, composed from SUB_W-input units.
// STYLE picks the AND-pair or the enable-tree structure; the function is equal.
// Assumes: combinational; no clock or reset is needed.
module wide_decoder #(
    parameter int               SUB_W = 4,
    parameter dec_pkg::compose_e STYLE = dec_pkg::COMPOSE_COINCIDENT
) (
    input  logic [2*SUB_W-1:0]        code_i,
    input  logic                      en_i,
    output logic [(1<<(2*SUB_W))-1:0] onehot_o
);
    localparam int IN_W  = 2 * SUB_W;
    localparam int OUT_N = 1 << IN_W;

    // Structure selection
    if (STYLE == dec_pkg::COMPOSE_TREE) begin : g_tree
        dec_tree #(.SUB_W(SUB_W)) u_core (
            .code_i (code_i),
            .en_i   (en_i),
            .line_o (onehot_o)
        );
    end else begin : g_coin
        dec_coincident #(.SUB_W(SUB_W)) u_core (
            .code_i (code_i),
            .en_i   (en_i),
            .line_o (onehot_o)
        );
    end

    // Guard: port-level function of the decoder
    always_comb begin
        AST_OFF_ALL_ZERO: assert (en_i || (onehot_o == '0))
            else $error("output active while disabled"); // R2
        AST_ON_ONE_HOT: assert (!en_i || ($countones(onehot_o) == 1))
            else $error("output not one-hot while enabled"); // R1
        AST_ON_RIGHT_BIT: assert (!en_i || onehot_o[code_i])
            else $error("addressed line not set"); // R1
        AST_NEVER_MULTI: assert ($onehot0(onehot_o) && (OUT_N > 1))
            else $error("multiple lines set"); // R1
    end

endmodule

// File: tb/wide_decoder_tb.sv
// Bench: drives both compositions with the same code/enable and checks each
// against a shift-based reference, plus against each other.
module wide_decoder_tb;
    localparam int SUB_W = 4;
    localparam int IN_W  = 2 * SUB_W;
    localparam int OUT_N = 1 << IN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IN_W-1:0]  code;
    logic             en;
    logic [OUT_N-1:0] z_coin;
    logic [OUT_N-1:0] z_tree;
    int               checks = 0;
    int               errors = 0;
    bit               done = 1'b0;

    // 100 MHz clock
    always #5 clk = ~clk;

    wide_decoder #(.SUB_W(SUB_W), .STYLE(dec_pkg::COMPOSE_COINCIDENT)) u_dut (
        .code_i (code), .en_i (en), .onehot_o (z_coin)
    );
    wide_decoder #(.SUB_W(SUB_W), .STYLE(dec_pkg::COMPOSE_TREE)) u_dut_tree (
        .code_i (code), .en_i (en), .onehot_o (z_tree)
    );

    // Reference: one bit at the code index, or nothing when disabled
    function automatic logic [OUT_N-1:0] ref_dec(input logic [IN_W-1:0] c, input logic e);
        logic [OUT_N-1:0] one;
        one = {{(OUT_N-1){1'b0}}, 1'b1};
        return e ? (one << c) : '0;
    endfunction

    task automatic check_vec(input logic [OUT_N-1:0] act, input logic [OUT_N-1:0] exp,
                             input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s code=%0d en=%0b actual=%h expected=%h", req, code, en, act, exp);
        end
    endtask

    // Apply one vector after the rising edge, check at the falling edge
    task automatic apply(input logic [IN_W-1:0] c, input logic e, input string req);
        @(posedge clk); #1;
        code = c; en = e;
        @(negedge clk);
        check_vec(z_coin, ref_dec(c, e), {req, " coincident"});
        check_vec(z_tree, ref_dec(c, e), {req, " tree"});
        check_vec(z_tree, z_coin, "R4 agreement");
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        code = '0; en = 1'b0;
        // Reset state: disabled, all outputs zero (R2)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_vec(z_coin, '0, "R2 reset");
        check_vec(z_tree, '0, "R2 reset");
        rst_n = 1'b1;

        // R6 directed corners
        apply(8'h00, 1'b1, "R6 code0");
        apply(8'hFF, 1'b1, "R6 code255");
        apply(8'h06, 1'b1, "R6 code6");
        // R3 nibble weighting
        apply(8'h24, 1'b1, "R3 code36");
        apply(8'h42, 1'b1, "R3 code66");
        apply(8'hF0, 1'b1, "R3 code240");
        apply(8'h0F, 1'b1, "R3 code15");
        // R2 disabled with busy codes
        apply(8'hFF, 1'b0, "R2 off255");
        apply(8'h00, 1'b0, "R2 off0");

        // Exhaustive sweep, both enable values (R1, R2, R4, R5)
        for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < OUT_N; c++) begin
                apply(IN_W'(c), e[0], (e != 0) ? "R1 sweep" : "R2 sweep");
            end
        end

        // Random mix (R1, R2, R5)
        for (int k = 0; k < 300; k++) begin
            logic [IN_W-1:0] rc;
            logic            re;
            rc = IN_W'($urandom);
            re = ($urandom % 4) != 0;
            apply(rc, re, re ? "R1 random" : "R2 random");
            // R5: only the addressed group may hold the set bit
            checks++;
            if (re && (z_tree[rc[IN_W-1:SUB_W]*16 +: 16] !== (16'h1 << rc[SUB_W-1:0]))) begin
                errors++;
                $display("FAIL R5 group code=%0d actual=%h expected=%h",
                         rc, z_tree[rc[IN_W-1:SUB_W]*16 +: 16], 16'h1 << rc[SUB_W-1:0]);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule